// File: doc/BRIEF.md
# Multi-Channel Timer with Edge-Aligned PWM

This block is a 16-bit up-counter with a programmable wrap limit, a power-of-two prescaler and a set of independent channels. The counter can be stepped from the bus clock or from an external clock pin. The external pin is first brought into the bus clock domain, and its rising edges are then counted. Each channel can act in one of three ways. As an input capture, it latches the counter when a chosen pin edge arrives. As an output compare, it raises a flag and can toggle, clear or set its pin when the counter reaches a programmed value. As an edge-aligned PWM, it drives a pulse whose width follows the channel value.

Software reaches every register through one synchronous port. A write takes effect on the clock edge. A read returns the addressed register combinationally. In PWM mode the duty value and the wrap limit are double-buffered: a value written while the timer runs takes effect only when the counter next wraps. Each channel also reports whether it owns its pin and whether it drives that pin. When a channel does not own its pin, general-purpose I/O keeps control of it.

Top module: `mtimer`

## Requirements
- R1: After reset every register reads 0, the counter does not advance, and ch_own, ch_drive and ch_out are all 0.
- R2: The clock-source field is control register (address 0) bits [4:3]. The value 01 steps from the bus clock, 11 steps from the external pin, and 00 or 10 stops the counter, which then holds its value.
- R3: The control field bits [2:0] hold n. The counter advances once every 2^n selected clock events, for n from 0 to 7.
- R4: With the external source selected, each rising edge of ext_clk_in counts once as a clock event after resynchronization. The pin must toggle at less than half the bus rate.
- R5: On the count step taken while the counter equals the modulo value (address 2), the counter goes to 0 and the overflow flag (control bit 7) sets. A modulo of 0 gives a full 16-bit roll-over.
- R6: A modulo value written while the counter runs takes effect at the next wrap. While the counter is stopped it takes effect at once. Any write to address 1 clears the counter and the prescaler.
- R7: Writing 1 to a flag bit clears it. When a flag set and a clear fall in the same cycle, the flag stays set.
- R8: Channel n has a configuration register at address 4+2n and a value register at address 5+2n. The configuration holds the mode in bits [1:0] (00 capture, 01 compare, 10 or 11 PWM), the edge/level select in bits [3:2], and the channel flag in bit 7.
- R9: In capture mode, edge/level select 01 captures on rising edges, 10 on falling edges and 11 on both. A selected edge latches the counter value present two bus clocks after the pin changes and sets the flag. An edge that is not selected changes neither the value nor the flag.
- R10: In compare and PWM modes, the flag sets on the count step taken while the counter equals the channel value. In compare mode the pin action is then 01 toggle, 10 drive low, or 11 drive high.
- R11: In PWM mode with edge/level select 10, ch_out is high while counter < channel value and low otherwise. With 01 or 11 the output is inverted.
- R12: A PWM channel value written while the counter runs takes effect at the next wrap. The value register reads back the newly written value at once.
- R13: With edge/level select 00 a channel releases its pin: ch_own, ch_drive and ch_out are 0, and compare matches still set the flag. A capture channel with a nonzero select owns its pin but does not drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | CNT_W (16) | Register write data |
| reg_rdata | output | CNT_W (16) | Read data for reg_addr |
| ext_clk_in | input | 1 | External count clock pin |
| ch_in | input | NCH (2) | Channel pin inputs for capture |
| ch_own | output | NCH (2) | Channel owns its pin |
| ch_drive | output | NCH (2) | Channel drives its pin as an output |
| ch_out | output | NCH (2) | Channel pin output level |

## Verification
The bench targets these boundary cases:
- Modulo and PWM updates that arrive mid-period. A design that loaded them at once would wrap early or change the duty cycle within the current period.
- A flag clear that lands on the exact cycle of a compare match. A design that let the clear win would lose the event.
- Capture timing through the pin resynchronizer, and edges that are not selected. A wrong latency shows up as an off-by-N captured value, and a wrong edge decode shows up as a spurious flag.
- Random modulo and prescaler settings, each checked against a closed-form count model, together with the divide-by-128 extreme and the full roll-over.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [1:0] {
      CH_CAP     = 2'b00,
      CH_CMP     = 2'b01,
      CH_PWM     = 2'b10,
      CH_PWM_ALT = 2'b11
   } ch_mode_e;

   localparam int unsigned ADR_CTL     = 0;
   localparam int unsigned ADR_CNT     = 1;
   localparam int unsigned ADR_MOD     = 2;
   localparam int unsigned ADR_CH_BASE = 4;

   localparam int unsigned CLKSEL_BUS  = 1;
   localparam int unsigned CLKSEL_EXT  = 3;
   localparam int unsigned FLAG_BIT    = 7;
endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], d};
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter import tmr_pkg::*; #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PS_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       clk_sel,
   input  logic [PS_W-1:0]  ps,
   input  logic             ext_q,
   input  logic             cnt_clr,
   input  logic             mod_wr,
   input  logic [CNT_W-1:0] mod_wdata,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] mod_sh,
   output logic             tick,
   output logic             wrap,
   output logic             running,
   output logic             ovf
);
   localparam int unsigned PRE_W = (1 << PS_W) - 1;

   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("tmr_counter: PS_W out of range");
   end

   logic             ext_prev, ext_rise, sel_ext, src;
   logic [PRE_W-1:0] pre_cnt, pre_lim;
   logic [CNT_W-1:0] mod_act, limit;

   assign sel_ext  = (clk_sel == 2'(CLKSEL_EXT));
   assign running  = (clk_sel == 2'(CLKSEL_BUS)) || sel_ext;
   assign ext_rise = ext_q & ~ext_prev;
   assign src      = running && (sel_ext ? ext_rise : 1'b1);
   assign pre_lim  = PRE_W'((32'd1 << ps) - 32'd1);
   assign tick     = src && (pre_cnt == pre_lim);
   assign limit    = (mod_act == '0) ? '1 : mod_act;
   assign wrap     = tick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev <= 1'b0;
         pre_cnt  <= '0;
         cnt      <= '0;
         mod_sh   <= '0;
         mod_act  <= '0;
         ovf      <= 1'b0;
      end else begin
         ext_prev <= ext_q;

         if (cnt_clr || !running)     pre_cnt <= '0;
         else if (src)                pre_cnt <= (pre_cnt == pre_lim) ? '0 : pre_cnt + PRE_W'(1);

         if (cnt_clr)                 cnt <= '0;
         else if (tick)               cnt <= wrap ? '0 : cnt + CNT_W'(1);

         if (mod_wr)                  mod_sh <= mod_wdata;

         if (!running)                mod_act <= mod_wr ? mod_wdata : mod_sh;
         else if (wrap)               mod_act <= mod_sh;

         if (wrap)                    ovf <= 1'b1;
         else if (ovf_clr)            ovf <= 1'b0;
      end
   end

   // R5: wrap returns the counter to zero and raises overflow
   a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !cnt_clr) |=> (cnt == '0 && ovf));

   // R2: stopped counter holds
   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !cnt_clr) |=> $stable(cnt));

   // R4: with the external source, only a resynchronized rising edge moves the count
   a_r4_ext_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ext && !ext_rise && !cnt_clr) |=> $stable(cnt));

   // R6: active limit changes only at a wrap while running
   a_r6_mod_buffered: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !wrap) |=> $stable(mod_act));

   // R7: set beats clear
   a_r7_ovf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && ovf_clr) |=> ovf);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel import tmr_pkg::*; #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_els,
   input  logic             cfg_clr,
   input  logic             val_wr,
   input  logic [CNT_W-1:0] val_wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             tick,
   input  logic             wrap,
   input  logic             running,
   input  logic             pin_in,
   output logic [7:0]       cfg_rd,
   output logic [CNT_W-1:0] val_rd,
   output logic             own,
   output logic             drive,
   output logic             out
);
   ch_mode_e         mode;
   logic [1:0]       els;
   logic             flag, cmp_q, pin_q, pin_prev;
   logic             rise, fall, is_cap, is_cmp, is_pwm;
   logic             cap_evt, match, flag_clr, pwm_lvl;
   logic [CNT_W-1:0] val_sh, val_act, cmp_ref;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_q)
   );

   assign rise     = pin_q & ~pin_prev;
   assign fall     = ~pin_q & pin_prev;
   assign is_cap   = (mode == CH_CAP);
   assign is_cmp   = (mode == CH_CMP);
   assign is_pwm   = (mode == CH_PWM) || (mode == CH_PWM_ALT);
   assign cap_evt  = is_cap && ((els[0] && rise) || (els[1] && fall));
   assign cmp_ref  = is_pwm ? val_act : val_sh;
   assign match    = !is_cap && tick && (cnt == cmp_ref);
   assign flag_clr = cfg_wr && cfg_clr;
   assign pwm_lvl  = (cnt < val_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= CH_CAP;
         els      <= 2'b00;
         flag     <= 1'b0;
         cmp_q    <= 1'b0;
         pin_prev <= 1'b0;
         val_sh   <= '0;
         val_act  <= '0;
      end else begin
         pin_prev <= pin_q;
         if (cfg_wr) begin
            mode <= ch_mode_e'(cfg_mode);
            els  <= cfg_els;
         end

         if (cap_evt || match)        flag <= 1'b1;
         else if (flag_clr)           flag <= 1'b0;

         if (cap_evt)                 val_sh <= cnt;
         else if (val_wr)             val_sh <= val_wdata;

         if (!running || !is_pwm)     val_act <= val_wr ? val_wdata : val_sh;
         else if (wrap)               val_act <= val_sh;

         if (match && is_cmp) begin
            case (els)
               2'b01:   cmp_q <= ~cmp_q;
               2'b10:   cmp_q <= 1'b0;
               2'b11:   cmp_q <= 1'b1;
               default: cmp_q <= cmp_q;
            endcase
         end
      end
   end

   assign own    = (els != 2'b00);
   assign drive  = own && !is_cap;
   assign out    = drive && (is_pwm ? ((els == 2'b10) ? pwm_lvl : ~pwm_lvl) : cmp_q);
   assign cfg_rd = {flag, 3'b000, els, mode};
   assign val_rd = val_sh;

   // R9: capture stores the counter of that cycle
   a_r9_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (val_sh == $past(cnt)));

   // R12: running PWM duty changes only at wrap
   a_r12_val_buffered: assert property (@(posedge clk) disable iff (!rst_n)
      (running && is_pwm && !wrap) |=> $stable(val_act));

   // R7: channel flag set beats clear
   a_r7_ch_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((cap_evt || match) && flag_clr) |=> flag);

   // R10: compare with set action drives high after match
   a_r10_compare_set: assert property (@(posedge clk) disable iff (!rst_n)
      (match && is_cmp && els == 2'b11) |=> cmp_q);
endmodule

// File: rtl/mtimer.sv
`timescale 1ns/1ps
module mtimer import tmr_pkg::*; #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned NCH         = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned PS_W        = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              ext_clk_in,
   input  logic [NCH-1:0]    ch_in,
   output logic [NCH-1:0]    ch_own,
   output logic [NCH-1:0]    ch_drive,
   output logic [NCH-1:0]    ch_out
);
   localparam int unsigned CTL_USED = PS_W + 2;

   if (NCH < 1 || (ADR_CH_BASE + 2 * NCH) > (1 << ADDR_W)) begin : g_bad_nch
      $error("mtimer: channel registers do not fit the address space");
   end
   if (CNT_W < 8 || CTL_USED > FLAG_BIT) begin : g_bad_width
      $error("mtimer: CNT_W or PS_W out of range");
   end

   logic [PS_W-1:0]  ps;
   logic [1:0]       clk_sel;
   logic             ext_q, ctl_wr;
   logic [CNT_W-1:0] cnt, mod_sh;
   logic             tick, wrap, running, ovf;
   logic [7:0]       ch_cfg_rd [NCH];
   logic [CNT_W-1:0] ch_val_rd [NCH];

   assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(ADR_CTL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps      <= '0;
         clk_sel <= 2'b00;
      end else if (ctl_wr) begin
         ps      <= reg_wdata[PS_W-1:0];
         clk_sel <= reg_wdata[PS_W+1:PS_W];
      end
   end

   tmr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_clk_in), .q(ext_q)
   );

   tmr_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_sel   (clk_sel),
      .ps        (ps),
      .ext_q     (ext_q),
      .cnt_clr   (reg_wr && (reg_addr == ADDR_W'(ADR_CNT))),
      .mod_wr    (reg_wr && (reg_addr == ADDR_W'(ADR_MOD))),
      .mod_wdata (reg_wdata),
      .ovf_clr   (ctl_wr && reg_wdata[FLAG_BIT]),
      .cnt       (cnt),
      .mod_sh    (mod_sh),
      .tick      (tick),
      .wrap      (wrap),
      .running   (running),
      .ovf       (ovf)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int unsigned CFG_A = ADR_CH_BASE + 2 * i;
      logic cfg_wr;
      assign cfg_wr = reg_wr && (reg_addr == ADDR_W'(CFG_A));

      tmr_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_wr    (cfg_wr),
         .cfg_mode  (reg_wdata[1:0]),
         .cfg_els   (reg_wdata[3:2]),
         .cfg_clr   (reg_wdata[FLAG_BIT]),
         .val_wr    (reg_wr && (reg_addr == ADDR_W'(CFG_A + 1))),
         .val_wdata (reg_wdata),
         .cnt       (cnt),
         .tick      (tick),
         .wrap      (wrap),
         .running   (running),
         .pin_in    (ch_in[i]),
         .cfg_rd    (ch_cfg_rd[i]),
         .val_rd    (ch_val_rd[i]),
         .own       (ch_own[i]),
         .drive     (ch_drive[i]),
         .out       (ch_out[i])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_CTL))
         reg_rdata = CNT_W'({ovf, {(FLAG_BIT-CTL_USED){1'b0}}, clk_sel, ps});
      else if (reg_addr == ADDR_W'(ADR_CNT))
         reg_rdata = cnt;
      else if (reg_addr == ADDR_W'(ADR_MOD))
         reg_rdata = mod_sh;
      for (int i = 0; i < NCH; i++) begin
         if (reg_addr == ADDR_W'(ADR_CH_BASE + 2 * i))     reg_rdata = CNT_W'(ch_cfg_rd[i]);
         if (reg_addr == ADDR_W'(ADR_CH_BASE + 2 * i + 1)) reg_rdata = ch_val_rd[i];
      end
   end
endmodule

// File: tb/test_mtimer.sv
`timescale 1ns/1ps
module test_mtimer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ext_clk_in = 1'b0;
   logic [1:0]  ch_in = '0;
   logic [1:0]  ch_own, ch_drive, ch_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   mtimer i_mtimer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk_in(ext_clk_in),
      .ch_in(ch_in), .ch_own(ch_own), .ch_drive(ch_drive), .ch_out(ch_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic run(input int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic stop_clear();
      wr(4'd0, 16'h0000);
      wr(4'd0, 16'h0080);
   endtask

   function automatic int exp_cnt(int k, int d, int m);
      int lim = (m == 0) ? 65536 : m + 1;
      return (k / d) % lim;
   endfunction

   function automatic bit exp_ovf(int k, int d, int m);
      int lim = (m == 0) ? 65536 : m + 1;
      return (k / d) >= lim;
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [15:0] v, c0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      foreach (v[i]) ;
      for (int a = 0; a < 8; a++) begin
         if (a == 3) continue;
         rd(4'(a), v); chk("R1 reg after reset", v, 0);
      end
      chk("R1 pins after reset", {ch_own, ch_drive, ch_out}, 0);
      run(10); rd(4'd1, v); chk("R1 counter stays stopped", v, 0);

      // R2/R5: bus clock, small modulo
      wr(4'd2, 16'd3); wr(4'd1, 0); wr(4'd0, 16'h0008);
      run(10); rd(4'd1, v); chk("R5 count wraps at modulo", v, exp_cnt(10, 1, 3));
      rd(4'd0, v); chk("R5 overflow flag", v[7], 1);
      wr(4'd0, 16'h0000); rd(4'd0, v); chk("R7 flag kept without clear", v[7], 1);
      wr(4'd0, 16'h0080); rd(4'd0, v); chk("R7 flag cleared by write-1", v[7], 0);

      // R2: stopped hold, and select 10 also stops
      rd(4'd1, c0); run(20); rd(4'd1, v); chk("R2 hold with select 00", v, c0);
      wr(4'd0, 16'h0010); run(15); rd(4'd1, v); chk("R2 hold with select 10", v, c0);

      // R3/R5 random settings against closed form
      for (int it = 0; it < 12; it++) begin
         int m, p, k;
         m = (it == 0) ? 0 : int'($urandom_range(60, 2));
         p = int'($urandom_range(3, 0));
         k = int'($urandom_range(400, 1));
         stop_clear();
         wr(4'd2, 16'(m)); wr(4'd1, 0); wr(4'd0, 16'(8 | p));
         run(k);
         rd(4'd1, v); chk("R3 R5 random count", v, exp_cnt(k, 1 << p, m));
         rd(4'd0, v); chk("R5 random overflow", v[7], exp_ovf(k, 1 << p, m));
      end

      // R3: divide by 128
      stop_clear(); wr(4'd2, 16'd50); wr(4'd1, 0); wr(4'd0, 16'h000F);
      run(300); rd(4'd1, v); chk("R3 divide by 128", v, 2);

      // R6: modulo buffered while running
      stop_clear(); wr(4'd2, 16'd9); wr(4'd1, 0); wr(4'd0, 16'h0008);
      for (int i = 0; i < 30; i++) begin rd(4'd1, v); if (v == 2) break; run(1); end
      wr(4'd2, 16'd4);
      run(3); rd(4'd1, v); chk("R6 old limit holds until wrap", v, 6);
      run(4); rd(4'd1, v); chk("R6 wrap at old limit", v, 0);
      run(4); rd(4'd1, v); chk("R6 new limit reached", v, 4);
      run(1); rd(4'd1, v); chk("R6 new limit wraps", v, 0);
      rd(4'd2, v); chk("R6 modulo reads back", v, 4);

      // R4: external clock
      stop_clear(); wr(4'd2, 0); wr(4'd1, 0); wr(4'd0, 16'h0018);
      for (int p = 0; p < 6; p++) begin
         ext_clk_in = 1'b1; run(3); ext_clk_in = 1'b0; run(3);
      end
      run(6); rd(4'd1, v); chk("R4 external edges counted", v, 6);
      run(20); rd(4'd1, v); chk("R4 no edges no count", v, 6);

      // R10/R8: compare toggle on channel 0
      stop_clear(); wr(4'd2, 16'd20); wr(4'd1, 0);
      wr(4'd4, 16'h0085); wr(4'd5, 16'd5); wr(4'd0, 16'h0008);
      run(5); rd(4'd4, v);
      chk("R10 no flag before match step", v[7], 0);
      chk("R10 output before match", ch_out[0], 0);
      run(1); rd(4'd4, v);
      chk("R10 flag on match step", v[7], 1);
      chk("R10 toggle output", ch_out[0], 1);
      chk("R8 config readback", v[3:0], 4'h5);
      chk("R13 compare owns and drives", {ch_own[0], ch_drive[0]}, 2'b11);

      // R13: software timer, pin released
      stop_clear(); wr(4'd1, 0); wr(4'd4, 16'h0081); wr(4'd5, 16'd3); wr(4'd0, 16'h0008);
      run(10); rd(4'd4, v);
      chk("R13 released pin", {ch_own[0], ch_drive[0], ch_out[0]}, 0);
      chk("R13 flag still sets", v[7], 1);

      // R7: clear colliding with match
      wr(4'd4, 16'h0081); rd(4'd4, v); chk("R7 channel flag cleared", v[7], 0);
      for (int i = 0; i < 30; i++) begin rd(4'd1, v); if (v == 3) break; run(1); end
      chk("R7 reached match count", v, 3);
      wr(4'd4, 16'h0081); rd(4'd4, v); chk("R7 set wins over clear", v[7], 1);

      // R11: high-true PWM on channel 1
      stop_clear(); wr(4'd2, 16'd9); wr(4'd1, 0);
      wr(4'd6, 16'h008A); wr(4'd7, 16'd3); wr(4'd0, 16'h0008);
      chk("R11 output at count 0", ch_out[1], 1);
      for (int k = 1; k <= 25; k++) begin
         run(1);
         chk("R11 PWM level", ch_out[1], ((k % 10) < 3) ? 1 : 0);
      end
      chk("R11 PWM drives pin", ch_drive[1], 1);

      // R12: buffered duty
      for (int i = 0; i < 30; i++) begin rd(4'd1, v); if (v == 5) break; run(1); end
      wr(4'd7, 16'd7);
      chk("R12 old duty until wrap", ch_out[1], 0);
      rd(4'd7, v); chk("R12 value reads back new", v, 7);
      run(7); chk("R12 new duty after wrap", ch_out[1], 1);

      // R11: low-true
      stop_clear(); wr(4'd1, 0); wr(4'd6, 16'h0086); wr(4'd0, 16'h0008);
      run(2); chk("R11 low-true below value", ch_out[1], 0);
      run(7); chk("R11 low-true above value", ch_out[1], 1);

      // R9: capture on channel 0
      stop_clear(); wr(4'd2, 0); wr(4'd1, 0); wr(4'd4, 16'h0084); wr(4'd0, 16'h0008);
      chk("R13 capture owns not drives", {ch_own[0], ch_drive[0]}, 2'b10);
      run(10); rd(4'd1, c0); ch_in[0] = 1'b1;
      run(5); rd(4'd5, v); chk("R9 rising capture value", v, c0 + 2);
      rd(4'd4, v); chk("R9 capture flag", v[7], 1);
      wr(4'd4, 16'h0084); ch_in[0] = 1'b0;
      run(6); rd(4'd4, v); chk("R9 falling edge ignored flag", v[7], 0);
      rd(4'd5, v); chk("R9 falling edge ignored value", v, c0 + 2);
      wr(4'd4, 16'h008C); rd(4'd1, c0); ch_in[0] = 1'b1;
      run(5); rd(4'd5, v); chk("R9 either-edge capture", v, c0 + 2);
      rd(4'd1, c0); ch_in[0] = 1'b0;
      run(5); rd(4'd5, v); chk("R9 either-edge falling capture", v, c0 + 2);

      summary();
   end
endmodule